// File: doc/BRIEF.md
# Chip Erase Verify Sequencer

This block is a host-side controller that erases a whole command-driven flash array with a closed loop. After a `start` strobe it first brings every byte to the charged state: it asks an external byte program engine to write 00H to each address in turn, using a request/acknowledge handshake. Only after the last byte has been acknowledged does it touch the array's command bus.

The erase loop then runs. Each erase pulse is two consecutive 20H command writes followed by a soak wait. The pulse ends when an A0H verify command is written together with the address under test. After a recovery wait the sequencer reads that address back. A byte that reads FFH is blank, and the verify pointer moves up. A byte that is not blank triggers another pulse, and verification resumes at that same stored address instead of rescanning from zero.

The run passes when the last address reads blank. It fails if the pulse budget runs out. In both cases the sequencer writes 00H to return the array to read mode, then raises `done`, with `fail` and the final `pulseCount` alongside it. The soak time, recovery time, array size and pulse budget are parameters, given in clock cycles and bytes.

Top module: `chipEraseSeq`

## Requirements
- R1: After `start`, the block asserts `pgmReq` with `pgmData` = 00H for every address from 0 up to `ARRAY_BYTES-1` in ascending order. `pgmReq` stays high until `pgmAck`. No command write or read happens on the bus before the last acknowledge.
- R2: An erase pulse is a 20H write followed by a second 20H write on the next cycle. At least `ERASE_CYC` clock cycles pass between the second 20H write and the following A0H write.
- R3: A verify writes A0H with `busAddr` set to the address under test. It then waits at least `RECOVER_CYC` cycles and issues one `busRd` at that same address. `busRdata` is taken one cycle after `busRd`.
- R4: Verification starts at address 0 after the first pulse and moves up one address per blank byte. A byte is blank only if it reads FFH. The run passes once address `ARRAY_BYTES-1` reads blank.
- R5: When a verified byte is not FFH, the next bus operation starts a new erase pulse. The next A0H write targets that same address.
- R6: If the byte verified after pulse number `MAX_PULSES` is not blank, the run ends with `fail` = 1 and no further pulse is issued.
- R7: Every run ends with a 00H command write on the cycle before `done` rises. `busy` falls at the same time.
- R8: `pulseCount` is cleared by `start`, increases by one per erase pulse, and holds the total number of pulses while `done` is high.
- R9: After reset, `busy`, `done`, `fail`, `pgmReq`, `busWr` and `busRd` are 0 and `pulseCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| start | input | 1 | One-cycle strobe that begins a run when idle |
| pgmReq | output | 1 | Request to the byte program engine |
| pgmAddr | output | ADDR_W | Address to precondition |
| pgmData | output | 8 | Value to program (always 00H) |
| pgmAck | input | 1 | One-cycle acknowledge from the program engine |
| busWr | output | 1 | Command write strobe |
| busRd | output | 1 | Read strobe |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | 8 | Command byte |
| busRdata | input | 8 | Read data, valid the cycle after `busRd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next `start` |
| fail | output | 1 | Pulse budget exhausted; valid with `done` |
| pulseCount | output | CNT_W | Number of erase pulses issued |

## Verification
Two situations are hard to reach from the ports. The first is the resume-after-failure path deep inside the array. The second is the exact edge of the pulse budget. The bench array model gives each byte its own count of pulses needed before it reads FFH. Scattering different counts across addresses makes verify fail several times at different pointers, and the model checks that each A0H address is the stored one rather than zero. Bytes needing exactly `MAX_PULSES` and one more than `MAX_PULSES` put the run on both sides of the budget, with short soak times keeping a thousand pulses affordable.

// File: rtl/eraseSeqPkg.sv
package eraseSeqPkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_ERASE  = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_VERIFY = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_READ   = 8'h00;
  localparam logic [BYTE_W-1:0] BLANK_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] PRE_BYTE   = 8'h00;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrClr;
    logic ptrInc;
    logic tmrLoadErase;
    logic tmrLoadRecover;
    logic pulseClr;
    logic pulseInc;
  } eraseStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic ptrLast;
    logic tmrZero;
    logic pulseLimit;
    logic byteBlank;
  } eraseStatus_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_ARM,
    ST_SOAK,
    ST_VCMD,
    ST_VREC,
    ST_VREAD,
    ST_VCHK,
    ST_FINISH
  } eraseState_t;

endpackage

// File: rtl/eraseSeqDatapath.sv
module eraseSeqDatapath
  import eraseSeqPkg::*;
#(
  parameter int ARRAY_BYTES = 131072,
  parameter int ADDR_W      = 17,
  parameter int ERASE_CYC   = 16,
  parameter int RECOVER_CYC = 6,
  parameter int MAX_PULSES  = 1000,
  parameter int CNT_W       = 10,
  parameter int TMR_W       = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  eraseStrobe_t        strobe,
  input  logic [BYTE_W-1:0]   busRdata,
  output eraseStatus_t        status,
  output logic [ADDR_W-1:0]   ptr,
  output logic [CNT_W-1:0]    pulseCnt
);

  localparam logic [ADDR_W-1:0] LAST_ADDR    = ADDR_W'(ARRAY_BYTES - 1);
  localparam logic [TMR_W-1:0]  ERASE_LOAD   = TMR_W'(ERASE_CYC - 1);
  localparam logic [TMR_W-1:0]  RECOVER_LOAD = TMR_W'(RECOVER_CYC - 1);
  localparam logic [CNT_W-1:0]  PULSE_MAX    = CNT_W'(MAX_PULSES);

  logic [TMR_W-1:0] tmr;

  // verify pointer, doubles as preconditioning address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.ptrClr) begin
      ptr <= '0;
    end else if (strobe.ptrInc) begin
      ptr <= ptr + 1'b1;
    end
  end

  // shared down-counter for soak and recovery waits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strobe.tmrLoadErase) begin
      tmr <= ERASE_LOAD;
    end else if (strobe.tmrLoadRecover) begin
      tmr <= RECOVER_LOAD;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.pulseClr) begin
      pulseCnt <= '0;
    end else if (strobe.pulseInc) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_comb begin
    status.ptrLast    = (ptr == LAST_ADDR);
    status.tmrZero    = (tmr == '0);
    status.pulseLimit = (pulseCnt == PULSE_MAX);
    status.byteBlank  = (busRdata == BLANK_BYTE);
  end

endmodule

// File: rtl/eraseSeqControl.sv
module eraseSeqControl
  import eraseSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pgmAck,
  input  eraseStatus_t      status,
  output eraseStrobe_t      strobe,
  output logic              pgmReq,
  output logic              busWr,
  output logic              busRd,
  output logic [BYTE_W-1:0] busWdata,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  eraseState_t state, stateNext;
  logic        failPend, failPendNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      failPend <= 1'b0;
    end else begin
      state    <= stateNext;
      failPend <= failPendNext;
    end
  end

  always_comb begin
    stateNext    = state;
    failPendNext = failPend;
    strobe       = '0;
    pgmReq       = 1'b0;
    busWr        = 1'b0;
    busRd        = 1'b0;
    busWdata     = CMD_READ;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.ptrClr   = 1'b1;
          strobe.pulseClr = 1'b1;
          failPendNext    = 1'b0;
          stateNext       = ST_PRE;
        end
      end
      ST_PRE: begin
        pgmReq = 1'b1;
        if (pgmAck) begin
          if (status.ptrLast) begin
            strobe.ptrClr = 1'b1;
            stateNext     = ST_SETUP;
          end else begin
            strobe.ptrInc = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        busWr     = 1'b1;
        busWdata  = CMD_ERASE;
        stateNext = ST_ARM;
      end
      ST_ARM: begin
        busWr               = 1'b1;
        busWdata            = CMD_ERASE;
        strobe.pulseInc     = 1'b1;
        strobe.tmrLoadErase = 1'b1;
        stateNext           = ST_SOAK;
      end
      ST_SOAK: begin
        if (status.tmrZero) stateNext = ST_VCMD;
      end
      ST_VCMD: begin
        busWr                 = 1'b1;
        busWdata              = CMD_VERIFY;
        strobe.tmrLoadRecover = 1'b1;
        stateNext             = ST_VREC;
      end
      ST_VREC: begin
        if (status.tmrZero) stateNext = ST_VREAD;
      end
      ST_VREAD: begin
        busRd     = 1'b1;
        stateNext = ST_VCHK;
      end
      ST_VCHK: begin
        if (status.byteBlank) begin
          if (status.ptrLast) begin
            stateNext = ST_FINISH;
          end else begin
            strobe.ptrInc = 1'b1;
            stateNext     = ST_VCMD;
          end
        end else if (status.pulseLimit) begin
          failPendNext = 1'b1;
          stateNext    = ST_FINISH;
        end else begin
          stateNext = ST_SETUP;
        end
      end
      ST_FINISH: begin
        busWr     = 1'b1;
        busWdata  = CMD_READ;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // completion flags held until the next run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else if (state == ST_IDLE && start) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else if (state == ST_FINISH) begin
      done <= 1'b1;
      fail <= failPend;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/chipEraseSeq.sv
module chipEraseSeq
  import eraseSeqPkg::*;
#(
  parameter int ARRAY_BYTES = 131072,
  parameter int ERASE_CYC   = 475000,
  parameter int RECOVER_CYC = 6,
  parameter int MAX_PULSES  = 1000,
  localparam int ADDR_W     = $clog2(ARRAY_BYTES),
  localparam int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              pgmReq,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [7:0]        pgmData,
  input  logic              pgmAck,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  pulseCount
);

  localparam int TMR_MAX = (ERASE_CYC > RECOVER_CYC) ? ERASE_CYC : RECOVER_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  eraseStrobe_t      strobe;
  eraseStatus_t      status;
  logic [ADDR_W-1:0] ptr;

  eraseSeqControl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .pgmAck   (pgmAck),
    .status   (status),
    .strobe   (strobe),
    .pgmReq   (pgmReq),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
  );

  eraseSeqDatapath #(
    .ARRAY_BYTES (ARRAY_BYTES),
    .ADDR_W      (ADDR_W),
    .ERASE_CYC   (ERASE_CYC),
    .RECOVER_CYC (RECOVER_CYC),
    .MAX_PULSES  (MAX_PULSES),
    .CNT_W       (CNT_W),
    .TMR_W       (TMR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busRdata (busRdata),
    .status   (status),
    .ptr      (ptr),
    .pulseCnt (pulseCount)
  );

  assign pgmAddr = ptr;
  assign busAddr = ptr;
  assign pgmData = PRE_BYTE;

endmodule

// File: rtl/chipEraseSeqChk.sv
module chipEraseSeqChk #(
  parameter int MAX_PULSES = 1000,
  parameter int CNT_W      = 10,
  parameter int ADDR_W     = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              pgmReq,
  input logic              pgmAck,
  input logic [ADDR_W-1:0] pgmAddr,
  input logic [7:0]        pgmData,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic              done,
  input logic              fail,
  input logic              busy,
  input logic [CNT_W-1:0]  pulseCount
);

  AST_PRE_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq |-> (!busWr && !busRd)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pgmReq && !pgmAck) |=> (pgmReq && $stable(pgmAddr))); // R1

  AST_PRE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq |-> (pgmData == 8'h00)); // R1

  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    pulseCount <= CNT_W'(MAX_PULSES)); // R6

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done); // R6

  AST_PULSE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCount != $past(pulseCount)) |->
      ((pulseCount == $past(pulseCount) + 1'b1) || (pulseCount == '0))); // R8

  AST_READ_MODE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busWr) && ($past(busWdata) == 8'h00) && !busy)); // R7

endmodule

bind chipEraseSeq chipEraseSeqChk #(
  .MAX_PULSES (MAX_PULSES),
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .pgmReq     (pgmReq),
  .pgmAck     (pgmAck),
  .pgmAddr    (pgmAddr),
  .pgmData    (pgmData),
  .busWr      (busWr),
  .busRd      (busRd),
  .busWdata   (busWdata),
  .done       (done),
  .fail       (fail),
  .busy       (busy),
  .pulseCount (pulseCount)
);

// File: tb/chipEraseSeq_tb_top.sv
`timescale 1ns/1ps
module chipEraseSeq_tb_top;

  localparam int ARR   = 16;
  localparam int ECYC  = 16;
  localparam int RCYC  = 3;
  localparam int MAXP  = 1000;
  localparam int AW    = $clog2(ARR);
  localparam int CW    = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          pgmReq, pgmAck;
  logic [AW-1:0] pgmAddr, busAddr;
  logic [7:0]    pgmData, busWdata, busRdata;
  logic          busWr, busRd, busy, done, fail;
  logic [CW-1:0] pulseCount;

  always #2.5 clk = ~clk;

  chipEraseSeq #(
    .ARRAY_BYTES (ARR),
    .ERASE_CYC   (ECYC),
    .RECOVER_CYC (RCYC),
    .MAX_PULSES  (MAXP)
  ) dut_i (
    .clk (clk), .rstN (rstN), .start (start),
    .pgmReq (pgmReq), .pgmAddr (pgmAddr), .pgmData (pgmData), .pgmAck (pgmAck),
    .busWr (busWr), .busRd (busRd), .busAddr (busAddr),
    .busWdata (busWdata), .busRdata (busRdata),
    .busy (busy), .done (done), .fail (fail), .pulseCount (pulseCount)
  );

  int errors = 0;
  int checks = 0;

  // array model state
  logic [7:0] mem [ARR];
  int  need [ARR];
  int  ackDly = 0;
  int  ackCnt = 0;
  int  cyc = 0;
  int  pulses = 0;
  bit  armed = 0;
  bit  fresh = 0;
  int  pulseCyc = 0;
  int  vcmdCyc = 0;
  int  vcmdAddr = 0;
  int  expVfy = 0;
  int  pgmCount = 0;
  int  pgmOrderBad = 0;
  int  preBad = 0;
  int  soakBad = 0;
  int  recBad = 0;
  int  vfyBad = 0;
  int  vfyCount = 0;
  int  lastCmd = -1;
  int  nonBlankSeen = 0;
  int  afterFailBad = 0;
  bit  expectPulse = 0;
  logic pgmAckQ = 1'b0;
  logic [7:0] rdQ = 8'h00;

  assign pgmAck   = pgmAckQ;
  assign busRdata = rdQ;

  always @(posedge clk) begin
    cyc++;
    pgmAckQ <= 1'b0;
    if (pgmReq && !pgmAckQ) begin
      if (busWr || busRd) preBad++;
      if (ackCnt >= ackDly) begin
        if (int'(pgmAddr) != pgmCount) pgmOrderBad++;
        if (pgmData != 8'h00) pgmOrderBad++;
        mem[pgmAddr] = 8'h00;
        pgmCount++;
        pgmAckQ <= 1'b1;
        ackCnt = 0;
      end else begin
        ackCnt++;
      end
    end
    if (busWr) begin
      lastCmd = busWdata;
      if (expectPulse && busWdata != 8'h20) afterFailBad++;
      expectPulse = 0;
      if (busWdata == 8'h20) begin
        if (armed) begin
          if (pulses == 0 && pgmCount != ARR) preBad++;
          if (pulses == 0) begin
            for (int i = 0; i < ARR; i++) if (mem[i] != 8'h00) preBad++;
          end
          pulses++;
          for (int i = 0; i < ARR; i++) if (pulses >= need[i]) mem[i] = 8'hFF;
          armed = 0;
          fresh = 1;
          pulseCyc = cyc;
        end else begin
          armed = 1;
        end
      end else begin
        if (armed) soakBad++;
        armed = 0;
      end
      if (busWdata == 8'hA0) begin
        if (fresh && (cyc - pulseCyc) <= ECYC) soakBad++;
        fresh = 0;
        if (int'(busAddr) != expVfy) vfyBad++;
        vcmdCyc = cyc;
        vcmdAddr = int'(busAddr);
        vfyCount++;
      end
    end
    if (busRd) begin
      if ((cyc - vcmdCyc) <= RCYC) recBad++;
      if (int'(busAddr) != vcmdAddr) recBad++;
      rdQ <= mem[busAddr];
      if (mem[busAddr] == 8'hFF) expVfy = int'(busAddr) + 1;
      else begin
        nonBlankSeen++;
        if (pulses < MAXP) expectPulse = 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // abstract expectation of pulses, verdict and verify count
  task automatic predict(output int ePulses, output int eFail, output int eVfy);
    int p = 0;
    ePulses = 0; eFail = 1; eVfy = 0;
    for (int k = 1; k <= MAXP; k++) begin
      ePulses = k;
      while (p < ARR && need[p] <= k) begin eVfy++; p++; end
      if (p == ARR) begin eFail = 0; break; end
      eVfy++;
    end
  endtask

  task automatic run_case(input string name, input int dly);
    int ePulses, eFail, eVfy;
    @(negedge clk);
    for (int i = 0; i < ARR; i++) mem[i] = 8'h5A ^ 8'(i);
    ackDly = dly; ackCnt = 0; pulses = 0; armed = 0; fresh = 0;
    expVfy = 0; pgmCount = 0; pgmOrderBad = 0; preBad = 0; soakBad = 0;
    recBad = 0; vfyBad = 0; vfyCount = 0; lastCmd = -1; nonBlankSeen = 0;
    afterFailBad = 0; expectPulse = 0;
    predict(ePulses, eFail, eVfy);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({name, " R8 count cleared at start"}, int'(pulseCount), 0);
    while (!done) @(negedge clk);
    check({name, " R1 all bytes preconditioned"}, pgmCount, ARR);
    check({name, " R1 order and no early bus use"}, pgmOrderBad + preBad, 0);
    check({name, " R2 soak wait"}, soakBad, 0);
    check({name, " R3 recovery and read address"}, recBad, 0);
    check({name, " R4 R5 verify address sequence"}, vfyBad, 0);
    check({name, " R5 verify count with resume"}, vfyCount, eVfy);
    check({name, " R5 pulse follows failed verify"}, afterFailBad, 0);
    check({name, " R6 fail flag"}, int'(fail), eFail);
    check({name, " R8 pulse count"}, int'(pulseCount), ePulses);
    check({name, " R8 model pulses"}, pulses, ePulses);
    check({name, " R7 read mode restored"}, lastCmd, 8'h00);
    check({name, " R7 not busy"}, int'(busy), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 fail", int'(fail), 0);
    check("R9 pgmReq", int'(pgmReq), 0);
    check("R9 bus idle", int'(busWr) + int'(busRd), 0);
    check("R9 pulseCount", int'(pulseCount), 0);
  endtask

  task automatic test_single_pulse();
    for (int i = 0; i < ARR; i++) need[i] = 1;
    run_case("single", 0);
  endtask

  task automatic test_scattered();
    for (int i = 0; i < ARR; i++) need[i] = 1;
    need[0] = 2; need[3] = 3; need[10] = 5; need[ARR-1] = 7;
    run_case("scattered", 2);
  endtask

  task automatic test_budget_edge();
    for (int i = 0; i < ARR; i++) need[i] = 1;
    need[7] = MAXP;
    run_case("budget_exact", 1);
  endtask

  task automatic test_budget_over();
    for (int i = 0; i < ARR; i++) need[i] = 2;
    need[12] = MAXP + 1;
    run_case("budget_over", 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_single_pulse();
    test_scattered();
    test_budget_edge();
    test_budget_over();
    test_single_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule